// File: doc/BRIEF.md
# 8-Bit ALU With Status Flags

This block is the arithmetic and logic stage of a small processor datapath. On each clock it takes two 8-bit operands, the current status byte and a 5-bit operation code, and registers three things: an 8-bit result, a new status byte and a write strobe. The write strobe tells the register file whether the result should be stored. It is low for compare and for single-bit test, because those two operations only update the status byte.

The operations are add and subtract, each with or without the incoming carry, and compare. There are the three bitwise logic operations, four rotates (two around the byte and two through carry) and three shifts (arithmetic left, arithmetic right and logical right). Single-bit test, set carry and complement carry complete the set. The status byte has a fixed layout. One flag position is shared: for arithmetic it reports signed overflow, and for logic, rotates and shifts it reports even parity. The two unused positions always read zero.

All outputs appear one clock after the inputs that produced them. An asynchronous active-low reset clears every output.

Top module: `alu8_core`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, result, status byte and write strobe are all zero.
- R2: The outputs are registered. They hold their value between clock edges and, after an edge, reflect the inputs sampled at that edge.
- R3: Codes 0 (add) and 1 (add plus carry-in from status bit 0) give the 8-bit sum and write strobe 1. C is the carry out of bit 7 and H the carry from bit 3 into bit 4. Overflow is set when both operands share a sign and the sum's sign differs. N is 0.
- R4: Codes 2 (subtract) and 3 (subtract minus carry-in) give a minus b (minus carry) and write strobe 1. C is the borrow and H the borrow out of bit 4. Overflow is set only when the operand signs differ and the difference's sign differs from a's sign. N is 1.
- R5: Code 4 (compare) sets every flag exactly as code 2 would, so Z is 1 exactly when a equals b, and it drives write strobe 0.
- R6: Codes 5 (AND), 6 (OR) and 7 (XOR) clear C and N and set the parity flag to 1 for an even number of one bits in the result. H is 1 for AND and 0 for OR and XOR. Write strobe is 1.
- R7: Codes 8 and 9 rotate a left and right around the byte. Codes 10 and 11 rotate left and right through carry. C takes the bit shifted out (bit 7 for left, bit 0 for right), H and N are 0, the parity flag shows even parity and write strobe is 1.
- R8: Code 12 shifts left and fills with 0. Code 13 shifts right and keeps bit 7. Code 14 shifts right and fills with 0. C, H, N, parity and write strobe follow the rule of R7.
- R9: For codes 0 to 14, S equals bit 7 of the result and Z is 1 exactly when the result is zero.
- R10: Code 15 tests bit b[2:0] of a. Z is the inverse of that bit, H is 1, N is 0, S, parity and C are passed through, and write strobe is 0.
- R11: Code 16 sets C and code 17 inverts C. Both clear H and N, pass S, Z and parity through, output a as the result and drive write strobe 1.
- R12: The status byte is laid out as bit 7 S, bit 6 Z, bit 4 H, bit 2 parity/overflow, bit 1 N and bit 0 C. Bits 5 and 3 are always 0, whatever the incoming status byte holds.
- R13: Codes 18 to 31 output a as the result and pass the status byte through with bits 5 and 3 cleared. Write strobe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (minuend, shifted or tested value) |
| b_i | input | 8 | Second operand; low 3 bits select the bit for code 15 |
| flags_i | input | 8 | Current status byte |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered new status byte |
| wr_en_o | output | 1 | Registered result write strobe |

## Verification
The hardest cases to reach are the carry-in paths. These are subtract-with-borrow and add-with-carry where the incoming carry alone changes the outcome: 0 minus 0 minus 1 must give FFh with a borrow out of bit 4, and FFh plus 0 plus 1 must give zero with both carries set. The other hard cases are the overflow edges where only the sign bit decides, such as 7Fh minus C0h and 80h minus 01h. Random operands almost never produce these cases together with a matching incoming carry, so directed vectors cover every carry-in state at each of them. A long run of random codes, operands and status bytes follows. Each vector is compared against an integer model on the next clock.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DW     = 8;
    localparam int unsigned FLAG_W = 8;

    // status byte bit positions
    localparam int unsigned FB_S  = 7;
    localparam int unsigned FB_Z  = 6;
    localparam int unsigned FB_H  = 4;
    localparam int unsigned FB_PV = 2;
    localparam int unsigned FB_N  = 1;
    localparam int unsigned FB_C  = 0;

    localparam logic [FLAG_W-1:0] FLAG_MASK = 8'hD7;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBC = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_RLC = 5'd8,
        OP_RRC = 5'd9,
        OP_RL  = 5'd10,
        OP_RR  = 5'd11,
        OP_SLA = 5'd12,
        OP_SRA = 5'd13,
        OP_SRL = 5'd14,
        OP_BIT = 5'd15,
        OP_SCF = 5'd16,
        OP_CCF = 5'd17
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    function automatic logic [FLAG_W-1:0] pack_flags(
        input logic s, input logic z, input logic h,
        input logic pv, input logic n, input logic c);
        logic [FLAG_W-1:0] f;
        f        = '0;
        f[FB_S]  = s;
        f[FB_Z]  = z;
        f[FB_H]  = h;
        f[FB_PV] = pv;
        f[FB_N]  = n;
        f[FB_C]  = c;
        return f;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int unsigned HB = W / 2;

    logic [W-1:0] bx;
    logic         ci;
    logic         co;

    always_comb begin
        bx = sub ? ~b : b;
        ci = sub ? ~cin : cin;
        {co, sum} = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
        // carry into the half position recovered from the sum bit
        h_out = (a[HB] ^ bx[HB] ^ sum[HB]) ^ sub;
        c_out = co ^ sub;
        v_out = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    input  alu8_pkg::logic_sel_e  sel,
    output logic [W-1:0]          res
);
    always_comb begin
        unique case (sel)
            alu8_pkg::LG_AND: res = a & b;
            alu8_pkg::LG_OR:  res = a | b;
            default:          res = a ^ b;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic [2:0]   mode,
    output logic [W-1:0] res,
    output logic         c_out
);
    always_comb begin
        res   = a;
        c_out = 1'b0;
        unique case (mode)
            3'd0: begin res = {a[W-2:0], a[W-1]}; c_out = a[W-1]; end
            3'd1: begin res = {a[0], a[W-1:1]};   c_out = a[0];   end
            3'd2: begin res = {a[W-2:0], cin};    c_out = a[W-1]; end
            3'd3: begin res = {cin, a[W-1:1]};    c_out = a[0];   end
            3'd4: begin res = {a[W-2:0], 1'b0};   c_out = a[W-1]; end
            3'd5: begin res = {a[W-1], a[W-1:1]}; c_out = a[0];   end
            3'd6: begin res = {1'b0, a[W-1:1]};   c_out = a[0];   end
            default: begin res = a; c_out = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int unsigned DATA_W = alu8_pkg::DW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [4:0]                  op_i,
    input  logic [DATA_W-1:0]           a_i,
    input  logic [DATA_W-1:0]           b_i,
    input  logic [alu8_pkg::FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0]           result_o,
    output logic [alu8_pkg::FLAG_W-1:0] flags_o,
    output logic                        wr_en_o
);
    import alu8_pkg::*;

    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
        logic              we;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic              c_in;
    logic              is_sub;
    logic              use_cin;
    logic [DATA_W-1:0] as_sum;
    logic              as_c, as_h, as_v;
    logic [DATA_W-1:0] lg_res;
    logic_sel_e        lg_sel;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [IDX_W-1:0]  bit_idx;
    logic              tested;

    assign c_in    = flags_i[FB_C];
    assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP);
    assign use_cin = (op_i == OP_ADC) || (op_i == OP_SBC);
    assign bit_idx = b_i[IDX_W-1:0];
    assign tested  = a_i[bit_idx];

    always_comb begin
        unique case (op_i)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            default: lg_sel = LG_XOR;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a     (a_i),
        .b     (b_i),
        .cin   (use_cin & c_in),
        .sub   (is_sub),
        .sum   (as_sum),
        .c_out (as_c),
        .h_out (as_h),
        .v_out (as_v)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a   (a_i),
        .b   (b_i),
        .sel (lg_sel),
        .res (lg_res)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .a     (a_i),
        .cin   (c_in),
        .mode  (op_i[2:0]),
        .res   (sh_res),
        .c_out (sh_c)
    );

    always_comb begin
        st_d.res = a_i;
        st_d.flg = flags_i & FLAG_MASK;
        st_d.we  = 1'b0;
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                st_d.res = as_sum;
                st_d.flg = pack_flags(as_sum[DATA_W-1], as_sum == '0, as_h,
                                      as_v, is_sub, as_c);
                st_d.we  = (op_i != OP_CMP);
            end
            OP_AND, OP_OR, OP_XOR: begin
                st_d.res = lg_res;
                st_d.flg = pack_flags(lg_res[DATA_W-1], lg_res == '0,
                                      op_i == OP_AND, ~^lg_res, 1'b0, 1'b0);
                st_d.we  = 1'b1;
            end
            OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SRL: begin
                st_d.res = sh_res;
                st_d.flg = pack_flags(sh_res[DATA_W-1], sh_res == '0, 1'b0,
                                      ~^sh_res, 1'b0, sh_c);
                st_d.we  = 1'b1;
            end
            OP_BIT: begin
                st_d.flg = pack_flags(flags_i[FB_S], ~tested, 1'b1,
                                      flags_i[FB_PV], 1'b0, c_in);
                st_d.we  = 1'b0;
            end
            OP_SCF, OP_CCF: begin
                st_d.flg = pack_flags(flags_i[FB_S], flags_i[FB_Z], 1'b0,
                                      flags_i[FB_PV], 1'b0,
                                      (op_i == OP_SCF) ? 1'b1 : ~c_in);
                st_d.we  = 1'b1;
            end
            default: begin
                st_d.res = a_i;
                st_d.flg = flags_i & FLAG_MASK;
                st_d.we  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign flags_o  = st_q.flg;
    assign wr_en_o  = st_q.we;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] op_i,
    input logic [7:0] a_i,
    input logic [7:0] b_i,
    input logic [7:0] flags_i,
    input logic [7:0] result_o,
    input logic [7:0] flags_o,
    input logic       wr_en_o
);
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R5
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i == 5'd4) |-> !wr_en_o && (flags_o[6] == $past(a_i == b_i)));

    // R4
    sub_n_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i == 5'd2 || op_i == 5'd3) |-> flags_o[1] && wr_en_o);

    // R6
    logic_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i >= 5'd5 && op_i <= 5'd7) |-> !flags_o[0] && !flags_o[1]);

    // R9
    sign_zero_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i <= 5'd14) |->
        (flags_o[7] == result_o[7]) && (flags_o[6] == (result_o == 8'h00)));

    // R10
    bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i == 5'd15) |->
        !wr_en_o && (flags_o[6] == !$past(a_i[b_i[2:0]])));

    // R11
    scf_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i == 5'd16) |-> flags_o[0] && wr_en_o);

    // R12
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_o[5] && !flags_o[3]);

    // R13
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(op_i >= 5'd18) |->
        !wr_en_o && result_o == $past(a_i) && flags_o == $past(flags_i & 8'hD7));

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] a = '0, b = '0, f = '0;
    logic [7:0] res_o, flg_o;
    logic       we_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .flags_i(f),
        .result_o(res_o), .flags_o(flg_o), .wr_en_o(we_o)
    );

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    function automatic logic [7:0] fl(input int s, z, h, pv, n, c);
        return {s[0], z[0], 1'b0, h[0], 1'b0, pv[0], n[0], c[0]};
    endfunction

    // behavioural model: {we, result, flags}
    function automatic logic [16:0] model(input int o, input int x, input int y, input int fi);
        int r = x; int c = fi & 1; int cy = 0; int hh = 0; int v = 0;
        int s7; int we = 0; logic [7:0] fo = fi[7:0] & 8'hD7;
        if (o <= 1) begin
            int ci = (o == 1) ? c : 0;
            r  = x + y + ci;
            cy = (r > 255); hh = ((x & 15) + (y & 15) + ci) > 15;
            r  = r & 255;
            v  = (((x >> 7) & 1) == ((y >> 7) & 1)) && (((r >> 7) & 1) != ((x >> 7) & 1));
            fo = fl(r >> 7, r == 0, hh, v, 0, cy); we = 1;
        end else if (o <= 4) begin
            int ci = (o == 3) ? c : 0;
            r  = x - y - ci;
            cy = (r < 0); hh = ((x & 15) - (y & 15) - ci) < 0;
            r  = r & 255;
            v  = (((x >> 7) & 1) != ((y >> 7) & 1)) && (((r >> 7) & 1) != ((x >> 7) & 1));
            fo = fl(r >> 7, r == 0, hh, v, 1, cy); we = (o != 4);
        end else if (o <= 7) begin
            r  = (o == 5) ? (x & y) : (o == 6) ? (x | y) : (x ^ y);
            fo = fl(r >> 7, r == 0, o == 5, (ones(r) % 2) == 0, 0, 0); we = 1;
        end else if (o <= 14) begin
            s7 = (x >> 7) & 1;
            case (o)
                8:  begin r = ((x << 1) | s7) & 255;      cy = s7;    end
                9:  begin r = (x >> 1) | ((x & 1) << 7);  cy = x & 1; end
                10: begin r = ((x << 1) | c) & 255;       cy = s7;    end
                11: begin r = (x >> 1) | (c << 7);        cy = x & 1; end
                12: begin r = (x << 1) & 255;             cy = s7;    end
                13: begin r = (x >> 1) | (x & 128);       cy = x & 1; end
                default: begin r = x >> 1;                cy = x & 1; end
            endcase
            fo = fl(r >> 7, r == 0, 0, (ones(r) % 2) == 0, 0, cy); we = 1;
        end else if (o == 15) begin
            fo = fl(fi >> 7, ((x >> (y & 7)) & 1) == 0, 1, fi >> 2, 0, c);
        end else if (o <= 17) begin
            fo = fl(fi >> 7, fi >> 6, 0, fi >> 2, 0, (o == 16) ? 1 : 1 - c); we = 1;
        end
        return {we[0], r[7:0], fo};
    endfunction

    function automatic string tag_of(input int o);
        if (o <= 1)  return "R3";
        if (o <= 3)  return "R4";
        if (o == 4)  return "R5";
        if (o <= 7)  return "R6";
        if (o <= 11) return "R7";
        if (o <= 14) return "R8";
        if (o == 15) return "R10";
        if (o <= 17) return "R11";
        return "R13";
    endfunction

    task automatic compare(input string tag, input logic [16:0] exp);
        vectors++;
        if ({we_o, res_o, flg_o} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h f=%h: actual we=%b res=%h flg=%h expected we=%b res=%h flg=%h",
                     tag, op, a, b, f, we_o, res_o, flg_o, exp[16], exp[15:8], exp[7:0]);
        end
    endtask

    // called at a falling edge; checks at the next falling edge
    task automatic apply(input int o, input int x, input int y, input int fi, input string tag);
        logic [16:0] exp;
        op = o[4:0]; a = x[7:0]; b = y[7:0]; f = fi[7:0];
        exp = model(o, x, y, fi);
        @(negedge clk);
        compare((tag == "") ? tag_of(o) : tag, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1", 17'h0);
        rst_n = 1'b1;
        #5 compare("R1", 17'h0);
        @(negedge clk);

        // R2: value holds until the next edge
        apply(0, 8'h01, 8'h01, 0, "R2");
        op = 5'd0; a = 8'h03; b = 8'h03; f = 8'h00;
        #5 compare("R2", model(0, 1, 1, 0));
        @(negedge clk);
        compare("R2", model(0, 3, 3, 0));

        // R3 corners
        apply(0, 8'h78, 8'h69, 0, "R3");
        apply(0, 8'hFF, 8'h01, 0, "R3");
        apply(0, 8'h0F, 8'h01, 0, "R3");
        apply(1, 8'hFF, 8'h00, 8'h01, "R3");
        apply(1, 8'hFF, 8'h00, 8'h00, "R3");
        apply(0, 8'h80, 8'h80, 0, "R3");
        // R4 corners
        apply(2, 8'h7F, 8'hC0, 0, "R4");
        apply(2, 8'h80, 8'h01, 0, "R4");
        apply(2, 8'h10, 8'h01, 0, "R4");
        apply(3, 8'h00, 8'h00, 8'h01, "R4");
        apply(3, 8'h00, 8'h00, 8'h00, "R4");
        apply(3, 8'h05, 8'h04, 8'h01, "R4");
        // R5
        apply(4, 8'h5A, 8'h5A, 8'h01, "R5");
        apply(4, 8'h10, 8'h20, 0, "R5");
        // R6 and R9 zero
        apply(5, 8'hF0, 8'h0F, 8'h01, "R9");
        apply(6, 8'h03, 8'h00, 8'h01, "R6");
        apply(7, 8'h07, 8'h00, 8'h01, "R6");
        apply(7, 8'hAA, 8'hAA, 0, "R9");
        // R7
        for (int o = 8; o <= 11; o++) begin
            apply(o, 8'h81, 0, 8'h00, "R7");
            apply(o, 8'h81, 0, 8'h01, "R7");
            apply(o, 8'h00, 0, 8'h01, "R7");
        end
        // R8
        for (int o = 12; o <= 14; o++) begin
            apply(o, 8'h81, 0, 8'h01, "R8");
            apply(o, 8'h01, 0, 8'h00, "R8");
        end
        // R10
        for (int i = 0; i < 8; i++) begin
            apply(15, 8'hA5, i, 8'h85, "R10");
            apply(15, 8'h5A, i + 8, 8'h00, "R10");
        end
        // R11
        apply(16, 8'h33, 0, 8'hD4, "R11");
        apply(17, 8'h33, 0, 8'hD5, "R11");
        apply(17, 8'h33, 0, 8'h00, "R11");
        // R12: spare bits set on the way in
        for (int o = 0; o < 32; o++) apply(o, 8'h6C, 8'h3A, 8'hFF, "R12");
        // R13
        apply(18, 8'hC3, 8'h11, 8'hFF, "R13");
        apply(31, 8'h00, 8'h00, 8'h2A, "R13");

        // mixed random vectors
        for (int k = 0; k < 4000; k++)
            apply($urandom_range(0, 31), $urandom_range(0, 255),
                  $urandom_range(0, 255), $urandom_range(0, 255), "");

        // R1: reset during operation
        op = 5'd0; a = 8'h12; b = 8'h34; f = 0;
        rst_n = 1'b0;
        #2 compare("R1", 17'h0);
        @(negedge clk);
        compare("R1", 17'h0);
        rst_n = 1'b1;
        @(negedge clk);
        apply(2, 8'h00, 8'h01, 0, "R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule